// File: doc/BRIEF.md
# Configurable PLD Output Macrocell

This block models a single output macrocell of a small programmable logic device. Eight product terms arrive from an AND array outside the block. A static configuration selects one of three cell personalities. In the complex personality, seven terms form a combinational sum and the eighth gates the pad. In the registered-flop personality, all eight terms are summed into a D flip-flop, and the pad is gated by the chip-wide active-low enable pin. In the registered-combinational personality, the complex behaviour is reused inside a registered-mode device.

A polarity bit can invert the value presented at the pad. The cell produces three things: a pad data bit, a pad enable bit (when the enable is low, the pad is released to high impedance), and a feedback bit for the array. Depending on the personality, the feedback bit is taken from the flop or from the pad. When the pad is released, the pad value is the level on the external input port. A synchronous reset stands in for the power-up clear of the flop.

Configuration encodings: `cfg_regmode` set to 0 selects complex mode and 1 selects registered mode. `cfg_flop` set to 1 selects the flop, and is only meaningful in registered mode. `cfg_inv` set to 1 selects active-low output.

Top module: `pld_out_cell`

Personalities, which are decoded from the configuration by a `unique case`:
- `CELL_CPLX`: entered whenever `cfg_regmode` is 0.
- `CELL_RCOMB`: entered when `cfg_regmode` is 1 and `cfg_flop` is 0.
- `CELL_RFLOP`: entered when `cfg_regmode` is 1 and `cfg_flop` is 1.

Transitions between personalities follow the static configuration inputs directly. The flop has two states: cleared, which is entered by a reset, and loaded, which is entered by any rising clock edge without reset.

## Requirements
- R1: In complex mode, `pad_dat` equals the OR of `pterm[6:0]` (after polarity), and `pterm[7]` has no effect on `pad_dat`.
- R2: In complex mode, `pad_oe` follows `pterm[7]` (1 = driven, 0 = released).
- R3: In registered-flop mode, the OR of all eight product terms is captured at each rising `clk` edge and appears on `pad_dat` after that edge, not before it.
- R4: In registered-flop mode, `pad_oe` equals the inverse of `oe_n_pin`, and `pterm[7]` only contributes to the sum.
- R5: In registered-flop mode, `fb` carries the true (non-inverted) flop value and ignores `pad_in`.
- R6: In the complex and registered-combinational modes, `fb` equals `pad_dat` while `pad_oe` is 1, and equals `pad_in` while `pad_oe` is 0.
- R7: With `cfg_inv` set to 1, `pad_dat` is the inverse of the sum (or of the flop value); with `cfg_inv` set to 0, it is the true value.
- R8: `rst` high at a rising edge clears the flop to 0, so in registered-flop mode `pad_dat` then reads `cfg_inv` (low for active-high, high for active-low).
- R9: In registered-combinational mode, `pad_dat` is the polarity-adjusted OR of `pterm[6:0]` and `pad_oe` follows `pterm[7]`, with no clock delay.
- R10: In complex mode, `cfg_flop` has no effect on `pad_dat`, `pad_oe` or `fb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Global register clock |
| rst | input | 1 | Synchronous reset, clears the flop |
| pterm | input | 8 | Product terms from the array |
| oe_n_pin | input | 1 | Global active-low output enable pin |
| cfg_regmode | input | 1 | 0 = complex mode, 1 = registered mode |
| cfg_flop | input | 1 | 1 = use the flop (registered mode only) |
| cfg_inv | input | 1 | 1 = active-low output |
| pad_in | input | 1 | Level on the pad from outside |
| pad_dat | output | 1 | Data driven toward the pad |
| pad_oe | output | 1 | Pad driver enable (0 = high impedance) |
| fb | output | 1 | Feedback bit into the array |

## Verification
Every combinational personality settles within the same cycle as its input change. The bench therefore drives on the falling edge and samples one time unit later. A registered-flop result is due one rising edge after its product terms are applied. The bench samples it on the following falling edge, and it also checks just before that edge that the old value still holds. A reset takes effect at the first rising edge it spans, so the cleared pad level is checked on the falling edge after that rising edge.

// File: rtl/pld_cell_pkg.sv
package pld_cell_pkg;

    typedef enum logic [1:0] {
        CELL_CPLX  = 2'd0,
        CELL_RCOMB = 2'd1,
        CELL_RFLOP = 2'd2
    } cell_kind_e;

endpackage

// File: rtl/pld_cell_decode.sv
module pld_cell_decode
    import pld_cell_pkg::*;
(
    input  logic       cfg_regmode,
    input  logic       cfg_flop,
    output cell_kind_e kind
);
    always_comb begin
        unique case ({cfg_regmode, cfg_flop})
            2'b00, 2'b01: kind = CELL_CPLX;
            2'b10:        kind = CELL_RCOMB;
            2'b11:        kind = CELL_RFLOP;
            default:      kind = CELL_CPLX;
        endcase
    end
endmodule

// File: rtl/pld_or_plane.sv
module pld_or_plane #(
    parameter int NUM_PT = 8,
    localparam int NUM_LOGIC = NUM_PT - 1
) (
    input  logic [NUM_PT-1:0] pterm,
    output logic              sum_logic,
    output logic              sum_all
);
    logic [NUM_PT-1:0] chain;

    generate
        for (genvar i = 0; i < NUM_PT; i++) begin : g_chain
            if (i == 0) begin : g_first
                assign chain[i] = pterm[i];
            end else begin : g_next
                assign chain[i] = chain[i-1] | pterm[i];
            end
        end
    endgenerate

    assign sum_logic = chain[NUM_LOGIC-1];
    assign sum_all   = chain[NUM_PT-1];
endmodule

// File: rtl/pld_cell_flop.sv
module pld_cell_flop (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    typedef enum logic {FLOP_CLEARED = 1'b0, FLOP_LOADED = 1'b1} flop_st_e;
    flop_st_e st_q;
    logic     val_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= FLOP_CLEARED;
            val_q <= 1'b0;
        end else begin
            st_q  <= FLOP_LOADED;
            val_q <= d;
        end
    end

    always_comb begin
        unique case (st_q)
            FLOP_CLEARED: q = 1'b0;
            FLOP_LOADED:  q = val_q;
            default:      q = 1'b0;
        endcase
    end
endmodule

// File: rtl/pld_pad_ctrl.sv
module pld_pad_ctrl
    import pld_cell_pkg::*;
(
    input  cell_kind_e kind,
    input  logic       sum_logic,
    input  logic       en_term,
    input  logic       flop_q,
    input  logic       oe_n_pin,
    input  logic       cfg_inv,
    input  logic       pad_in,
    output logic       pad_dat,
    output logic       pad_oe,
    output logic       fb
);
    always_comb begin
        unique case (kind)
            CELL_CPLX, CELL_RCOMB: begin
                pad_dat = sum_logic ^ cfg_inv;
                pad_oe  = en_term;
                fb      = en_term ? (sum_logic ^ cfg_inv) : pad_in;
            end
            CELL_RFLOP: begin
                pad_dat = flop_q ^ cfg_inv;
                pad_oe  = ~oe_n_pin;
                fb      = flop_q;
            end
            default: begin
                pad_dat = 1'b0;
                pad_oe  = 1'b0;
                fb      = pad_in;
            end
        endcase
    end
endmodule

// File: rtl/pld_out_cell.sv
module pld_out_cell
    import pld_cell_pkg::*;
#(
    parameter int NUM_PT = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_PT-1:0] pterm,
    input  logic              oe_n_pin,
    input  logic              cfg_regmode,
    input  logic              cfg_flop,
    input  logic              cfg_inv,
    input  logic              pad_in,
    output logic              pad_dat,
    output logic              pad_oe,
    output logic              fb
);
    localparam int EN_IDX = NUM_PT - 1;

    cell_kind_e kind;
    logic       sum_logic;
    logic       sum_all;
    logic       flop_q;

    pld_cell_decode u_decode (
        .cfg_regmode (cfg_regmode),
        .cfg_flop    (cfg_flop),
        .kind        (kind)
    );

    pld_or_plane #(.NUM_PT(NUM_PT)) u_or (
        .pterm     (pterm),
        .sum_logic (sum_logic),
        .sum_all   (sum_all)
    );

    pld_cell_flop u_flop (
        .clk (clk),
        .rst (rst),
        .d   (sum_all),
        .q   (flop_q)
    );

    pld_pad_ctrl u_pad (
        .kind      (kind),
        .sum_logic (sum_logic),
        .en_term   (pterm[EN_IDX]),
        .flop_q    (flop_q),
        .oe_n_pin  (oe_n_pin),
        .cfg_inv   (cfg_inv),
        .pad_in    (pad_in),
        .pad_dat   (pad_dat),
        .pad_oe    (pad_oe),
        .fb        (fb)
    );
endmodule

// File: rtl/pld_out_cell_chk.sv
module pld_out_cell_chk #(
    parameter int NUM_PT = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [NUM_PT-1:0] pterm,
    input logic              oe_n_pin,
    input logic              cfg_regmode,
    input logic              cfg_flop,
    input logic              cfg_inv,
    input logic              pad_in,
    input logic              pad_dat,
    input logic              pad_oe,
    input logic              fb
);
    logic flop_cell;
    assign flop_cell = cfg_regmode & cfg_flop;

    // R3: flop captures the full sum at the previous edge
    p_flop_capture_r3: assert property (@(posedge clk) disable iff (rst)
        (flop_cell && $past(flop_cell) && !$past(rst))
            |-> (fb == (|$past(pterm))))
        else $error("p_flop_capture_r3");

    // R4: global pin gates a flop cell
    p_flop_oe_r4: assert property (@(posedge clk) disable iff (rst)
        flop_cell |-> (pad_oe == !oe_n_pin))
        else $error("p_flop_oe_r4");

    // R2: complex cell enable comes from the last product term
    p_cplx_oe_r2: assert property (@(posedge clk) disable iff (rst)
        !cfg_regmode |-> (pad_oe == pterm[NUM_PT-1]))
        else $error("p_cplx_oe_r2");

    // R6: a released combinational pad feeds back the outside level
    p_fb_pad_r6: assert property (@(posedge clk) disable iff (rst)
        (!flop_cell && !pad_oe) |-> (fb == pad_in))
        else $error("p_fb_pad_r6");

    // R8: right after reset, a flop cell shows the cleared level
    p_reset_level_r8: assert property (@(posedge clk) disable iff (rst)
        (flop_cell && $past(flop_cell) && $past(rst)) |-> (pad_dat == cfg_inv))
        else $error("p_reset_level_r8");
endmodule

bind pld_out_cell pld_out_cell_chk #(.NUM_PT(NUM_PT)) u_chk (.*);

// File: tb/pld_out_cell_bench.sv
module pld_out_cell_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] pterm = '0;
    logic       oe_n_pin = 1'b1;
    logic       cfg_regmode = 1'b0;
    logic       cfg_flop = 1'b0;
    logic       cfg_inv = 1'b0;
    logic       pad_in = 1'b0;
    logic       pad_dat, pad_oe, fb;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pld_out_cell u_pld_out_cell (
        .clk(clk), .rst(rst), .pterm(pterm), .oe_n_pin(oe_n_pin),
        .cfg_regmode(cfg_regmode), .cfg_flop(cfg_flop), .cfg_inv(cfg_inv),
        .pad_in(pad_in), .pad_dat(pad_dat), .pad_oe(pad_oe), .fb(fb)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic set_cfg(input logic rm, input logic fl, input logic inv);
        @(negedge clk);
        cfg_regmode = rm; cfg_flop = fl; cfg_inv = inv;
    endtask

    task automatic t_reset(input logic inv);
        set_cfg(1'b1, 1'b1, inv);
        rst = 1'b1; pterm = 8'hFF; oe_n_pin = 1'b0;
        @(negedge clk);
        #1;
        chk("R8 pad after reset", pad_dat, inv);
        chk("R5 fb after reset", fb, 1'b0);
        rst = 1'b0;
    endtask

    // combinational cell: complex (rm=0) or registered-comb (rm=1)
    task automatic t_comb(input logic rm, input logic inv, input string req);
        set_cfg(rm, 1'b0, inv);
        for (int v = 0; v < 256; v += 37) begin
            @(negedge clk);
            pterm = v[7:0]; pad_in = v[2];
            #1;
            chk({req, " R1/R7 data"}, pad_dat, (|pterm[6:0]) ^ inv);
            chk({req, " R2 enable"}, pad_oe, pterm[7]);
            chk({req, " R6 feedback"}, fb, pterm[7] ? ((|pterm[6:0]) ^ inv) : pad_in);
        end
        // only the enable term high: data must stay at inactive level
        @(negedge clk);
        pterm = 8'h80; #1;
        chk({req, " R1 pt7 excluded"}, pad_dat, inv);
        // released pad: feedback tracks outside level both ways
        @(negedge clk);
        pterm = 8'h01; pad_in = 1'b1; #1;
        chk({req, " R6 released fb hi"}, fb, 1'b1);
        pad_in = 1'b0; #1;
        chk({req, " R6 released fb lo"}, fb, 1'b0);
    endtask

    task automatic t_flop(input logic inv);
        logic exp_q;
        t_reset(inv);
        exp_q = 1'b0;
        for (int v = 0; v < 6; v++) begin
            logic [7:0] pat;
            pat = (v == 1) ? 8'h80 : (v == 3) ? 8'h04 : 8'h00;
            pterm = pat; pad_in = ~exp_q; oe_n_pin = v[0];
            #1;
            chk("R3 holds before edge", pad_dat, exp_q ^ inv);
            chk("R4 enable from pin", pad_oe, ~v[0]);
            chk("R5 fb ignores pad_in", fb, exp_q);
            @(negedge clk);
            exp_q = |pat;
            #1;
            chk("R3/R7 captured", pad_dat, exp_q ^ inv);
            chk("R5 fb true value", fb, exp_q);
        end
        // mid-run reset
        pterm = 8'h01;
        @(negedge clk);
        #1;
        chk("R3 loaded one", fb, 1'b1);
        rst = 1'b1;
        @(negedge clk);
        #1;
        chk("R8 mid-run clear", pad_dat, inv);
        rst = 1'b0;
    endtask

    task automatic t_cfg_ignored();
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            cfg_regmode = 1'b0; cfg_inv = k[0]; cfg_flop = 1'b0;
            pterm = k[1] ? 8'h82 : 8'h02; pad_in = k[0];
            #1;
            begin
                logic d0, o0, f0;
                d0 = pad_dat; o0 = pad_oe; f0 = fb;
                cfg_flop = 1'b1; #1;
                chk("R10 data", pad_dat, d0);
                chk("R10 enable", pad_oe, o0);
                chk("R10 feedback", fb, f0);
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset(1'b0);
        t_reset(1'b1);
        t_comb(1'b0, 1'b0, "cplx hi");
        t_comb(1'b0, 1'b1, "cplx lo");
        t_comb(1'b1, 1'b0, "R9 rcomb hi");
        t_comb(1'b1, 1'b1, "R9 rcomb lo");
        t_flop(1'b0);
        t_flop(1'b1);
        t_cfg_ignored();
        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule